// File: doc/BRIEF.md
# NAND Read-Retry OTP Page Fetch Sequencer

This block drives a raw NAND command/address/data bus to read the one-time-programmable page that holds a flash device's read-retry tables. After a start pulse it resets the device, switches the device's private parameter register into OTP access, and runs a three-opcode unlock chain. It then reads the requested page from column zero for the requested number of bytes and passes each byte out with a one-cycle valid strobe.

Once the data phase ends, the sequencer resets the device again and clears the parameter register. A dummy page read of page zero with no data cycles follows, which leaves the device in normal operation. The sequencer does not interpret the bytes it fetches.

The bus is abstracted to one transfer per clock. Exactly one of four strobes marks the kind of transfer: command latch, address latch, data write, or data read. The strobe carries its byte on the output data lines, or takes it from the input data lines on a read. A ready/busy input is polled during wait steps, and a programmable limit on busy cycles guards each wait. If a wait exceeds that limit, every remaining step is abandoned and the run ends with an error.

Top module: `nand_otp_fetch`

## Requirements
- R1: After reset, busy, done, error, rdValid and all four bus strobes (nandCle, nandAle, nandWrEn, nandRdEn) are low.
- R2: A run opens with command 0xFF, then a wait for ready. It continues with command 0x36, an address cycle of 0x38, a data write of 0x52 and command 0x16. It then sends commands 0x17, 0x04 and 0x19, in that order.
- R3: The page read is framed as follows: command 0x00, two address cycles of 0x00, and three address cycles carrying pageAddr least significant byte first. Command 0x30 and a wait for ready come next. The frame ends with exactly byteLen data-read cycles (nandRdEn).
- R4: Each byte on nandDqIn during a data-read cycle appears on rdData with rdValid high in the following cycle, in read order.
- R5: After the data phase, the sequencer sends command 0xFF and waits for ready. It then sends command 0x36, an address cycle of 0x38, a data write of 0x00 and command 0x16.
- R6: The run closes with command 0x00, five address cycles of 0x00, command 0x30 and a wait for ready, with no data-read cycles. It then pulses done for one cycle with error low and busy low.
- R7: If a wait step sees nandReady low for busyLimit+1 consecutive cycles, no further bus cycles are issued, and done pulses with error high. A wait that sees exactly busyLimit busy cycles continues normally. error stays high until the next accepted start.
- R8: start is ignored while busy is high. pageAddr, byteLen and busyLimit are sampled only on the accepted start.
- R9: With byteLen of zero, the page read has no data-read cycles and every other bus cycle is unchanged.
- R10: At most one bus strobe is high in any cycle, and none is high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| pageAddr | input | 24 | Row address of the OTP page |
| byteLen | input | LEN_W | Number of bytes to read |
| busyLimit | input | TO_W | Busy cycles tolerated per wait step |
| nandCle | output | 1 | Command transfer this cycle |
| nandAle | output | 1 | Address transfer this cycle |
| nandWrEn | output | 1 | Data write transfer this cycle |
| nandRdEn | output | 1 | Data read transfer this cycle |
| nandDqOut | output | 8 | Byte driven for command, address or write |
| nandDqIn | input | 8 | Byte returned by the device on a read |
| nandReady | input | 1 | Device ready (high) or busy (low) |
| rdData | output | 8 | Fetched byte |
| rdValid | output | 1 | rdData holds a new byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run aborted on a busy timeout |

## Verification
The in-line properties check the following on every cycle:
- the single-strobe rule and bus silence when idle;
- the one-cycle relation between a read strobe and the byte on rdData;
- that an error can only rise out of a wait step, and that the busy counter never passes its limit;
- that done marks the end of busy.

The ordering of the opcode chain, the row byte order, the exact byte count and the abort truncation points can only be shown by the bench's scenarios. The bench logs every bus transfer and compares it with an independently built list.

// File: rtl/otp_fetch_pkg.sv
package otp_fetch_pkg;
  localparam int DQ_W    = 8;
  localparam int COL_CYC = 2;
  localparam int ROW_CYC = 3;
  localparam int ROW_W   = ROW_CYC * DQ_W;
  localparam int REP_MAX = (COL_CYC > ROW_CYC) ? COL_CYC : ROW_CYC;
  localparam int REP_W   = $clog2(REP_MAX);
  localparam int STEP_CNT = 27;
  localparam int STEP_W  = $clog2(STEP_CNT);

  localparam logic [DQ_W-1:0] OPC_RESET   = 8'hFF;
  localparam logic [DQ_W-1:0] OPC_PARM_IN = 8'h36;
  localparam logic [DQ_W-1:0] OPC_PARM_GO = 8'h16;
  localparam logic [DQ_W-1:0] OPC_UNLK_A  = 8'h17;
  localparam logic [DQ_W-1:0] OPC_UNLK_B  = 8'h04;
  localparam logic [DQ_W-1:0] OPC_UNLK_C  = 8'h19;
  localparam logic [DQ_W-1:0] OPC_RD_SET  = 8'h00;
  localparam logic [DQ_W-1:0] OPC_RD_GO   = 8'h30;
  localparam logic [DQ_W-1:0] PREG_ADDR   = 8'h38;
  localparam logic [DQ_W-1:0] PREG_OTP_ON = 8'h52;
  localparam logic [DQ_W-1:0] PREG_CLEAR  = 8'h00;

  typedef enum logic [3:0] {
    K_CMD, K_ADDR, K_WR, K_COLS, K_ROWS, K_ZROWS, K_WAIT, K_READ, K_END
  } stepKindT;

  typedef struct packed {
    stepKindT        kind;
    logic [DQ_W-1:0] val;
  } stepT;

  typedef struct packed {
    logic             cmdStb;
    logic             addrStb;
    logic             wrStb;
    logic             rdStb;
    logic             rowSel;
    logic [REP_W-1:0] rowIdx;
    logic [DQ_W-1:0]  lit;
    logic             waitOn;
    logic             load;
  } strobeT;

  function automatic stepT mkStep(input stepKindT k, input logic [DQ_W-1:0] v);
    stepT s;
    s.kind = k;
    s.val  = v;
    return s;
  endfunction

  // Fixed step program: unlock, page read, restore, closing dummy read.
  function automatic stepT stepAt(input logic [STEP_W-1:0] idx);
    case (idx)
      5'd0:  return mkStep(K_CMD,   OPC_RESET);
      5'd1:  return mkStep(K_WAIT,  '0);
      5'd2:  return mkStep(K_CMD,   OPC_PARM_IN);
      5'd3:  return mkStep(K_ADDR,  PREG_ADDR);
      5'd4:  return mkStep(K_WR,    PREG_OTP_ON);
      5'd5:  return mkStep(K_CMD,   OPC_PARM_GO);
      5'd6:  return mkStep(K_CMD,   OPC_UNLK_A);
      5'd7:  return mkStep(K_CMD,   OPC_UNLK_B);
      5'd8:  return mkStep(K_CMD,   OPC_UNLK_C);
      5'd9:  return mkStep(K_CMD,   OPC_RD_SET);
      5'd10: return mkStep(K_COLS,  '0);
      5'd11: return mkStep(K_ROWS,  '0);
      5'd12: return mkStep(K_CMD,   OPC_RD_GO);
      5'd13: return mkStep(K_WAIT,  '0);
      5'd14: return mkStep(K_READ,  '0);
      5'd15: return mkStep(K_CMD,   OPC_RESET);
      5'd16: return mkStep(K_WAIT,  '0);
      5'd17: return mkStep(K_CMD,   OPC_PARM_IN);
      5'd18: return mkStep(K_ADDR,  PREG_ADDR);
      5'd19: return mkStep(K_WR,    PREG_CLEAR);
      5'd20: return mkStep(K_CMD,   OPC_PARM_GO);
      5'd21: return mkStep(K_CMD,   OPC_RD_SET);
      5'd22: return mkStep(K_COLS,  '0);
      5'd23: return mkStep(K_ZROWS, '0);
      5'd24: return mkStep(K_CMD,   OPC_RD_GO);
      5'd25: return mkStep(K_WAIT,  '0);
      default: return mkStep(K_END, '0);
    endcase
  endfunction
endpackage

// File: rtl/otp_fetch_ctrl.sv
module otp_fetch_ctrl
  import otp_fetch_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   waitDone,
  input  logic   waitFail,
  input  logic   readLast,
  input  logic   lenZero,
  output strobeT stb,
  output logic   busy,
  output logic   done,
  output logic   error
);
  logic              running;
  logic [STEP_W-1:0] stepIdx;
  logic [REP_W-1:0]  repCnt;
  logic              doneQ;
  logic              errQ;
  stepT              cur;
  logic              advance;
  logic              finish;
  logic              fail;
  logic              repeatStep;

  always_comb begin
    cur        = stepAt(stepIdx);
    stb        = '0;
    advance    = 1'b0;
    finish     = 1'b0;
    fail       = 1'b0;
    repeatStep = 1'b0;
    stb.load   = !running && start;
    if (running) begin
      case (cur.kind)
        K_CMD: begin
          stb.cmdStb = 1'b1;
          stb.lit    = cur.val;
          advance    = 1'b1;
        end
        K_ADDR: begin
          stb.addrStb = 1'b1;
          stb.lit     = cur.val;
          advance     = 1'b1;
        end
        K_WR: begin
          stb.wrStb = 1'b1;
          stb.lit   = cur.val;
          advance   = 1'b1;
        end
        K_COLS: begin
          stb.addrStb = 1'b1;
          repeatStep  = 1'b1;
          advance     = (repCnt == REP_W'(COL_CYC - 1));
        end
        K_ROWS: begin
          stb.addrStb = 1'b1;
          stb.rowSel  = 1'b1;
          stb.rowIdx  = repCnt;
          repeatStep  = 1'b1;
          advance     = (repCnt == REP_W'(ROW_CYC - 1));
        end
        K_ZROWS: begin
          stb.addrStb = 1'b1;
          repeatStep  = 1'b1;
          advance     = (repCnt == REP_W'(ROW_CYC - 1));
        end
        K_WAIT: begin
          stb.waitOn = 1'b1;
          advance    = waitDone;
          fail       = waitFail;
        end
        K_READ: begin
          if (lenZero) begin
            advance = 1'b1;
          end else begin
            stb.rdStb = 1'b1;
            advance   = readLast;
          end
        end
        default: finish = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      stepIdx <= '0;
      repCnt  <= '0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          stepIdx <= '0;
          repCnt  <= '0;
          errQ    <= 1'b0;
        end
      end else if (fail) begin
        running <= 1'b0;
        doneQ   <= 1'b1;
        errQ    <= 1'b1;
      end else if (finish) begin
        running <= 1'b0;
        doneQ   <= 1'b1;
      end else if (advance) begin
        stepIdx <= stepIdx + STEP_W'(1);
        repCnt  <= '0;
      end else if (repeatStep) begin
        repCnt <= repCnt + REP_W'(1);
      end
    end
  end

  assign busy  = running;
  assign done  = doneQ;
  assign error = errQ;

  // R10
  one_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cmdStb, stb.addrStb, stb.wrStb, stb.rdStb}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(stb.cmdStb || stb.addrStb || stb.wrStb || stb.rdStb));

  // R7
  abort_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $past(stb.waitOn));

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R8
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !fail && !finish) |=> busy);
endmodule

// File: rtl/otp_fetch_dp.sv
module otp_fetch_dp
  import otp_fetch_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [ROW_W-1:0] pageAddr,
  input  logic [LEN_W-1:0] byteLen,
  input  logic [TO_W-1:0]  busyLimit,
  input  logic [DQ_W-1:0]  nandDqIn,
  input  logic             nandReady,
  output logic             waitDone,
  output logic             waitFail,
  output logic             readLast,
  output logic             lenZero,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWrEn,
  output logic             nandRdEn,
  output logic [DQ_W-1:0]  nandDqOut,
  output logic [DQ_W-1:0]  rdData,
  output logic             rdValid
);
  logic [ROW_W-1:0] pageReg;
  logic [LEN_W-1:0] lenReg;
  logic [TO_W-1:0]  limitReg;
  logic [LEN_W-1:0] readIdx;
  logic [TO_W-1:0]  waitCnt;
  logic [DQ_W-1:0]  rowByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg  <= '0;
      lenReg   <= '0;
      limitReg <= '0;
      readIdx  <= '0;
      waitCnt  <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= stb.rdStb;
      if (stb.rdStb) rdData <= nandDqIn;
      if (stb.load) begin
        pageReg  <= pageAddr;
        lenReg   <= byteLen;
        limitReg <= busyLimit;
        readIdx  <= '0;
      end else if (stb.rdStb) begin
        readIdx <= readIdx + LEN_W'(1);
      end
      if (stb.waitOn && !nandReady) waitCnt <= waitCnt + TO_W'(1);
      else                          waitCnt <= '0;
    end
  end

  always_comb begin
    rowByte = '0;
    for (int i = 0; i < ROW_CYC; i++) begin
      if (stb.rowIdx == REP_W'(i)) rowByte = pageReg[i*DQ_W +: DQ_W];
    end
  end

  assign waitDone  = stb.waitOn && nandReady;
  assign waitFail  = stb.waitOn && !nandReady && (waitCnt == limitReg);
  assign readLast  = (readIdx == lenReg - LEN_W'(1));
  assign lenZero   = (lenReg == '0);
  assign nandCle   = stb.cmdStb;
  assign nandAle   = stb.addrStb;
  assign nandWrEn  = stb.wrStb;
  assign nandRdEn  = stb.rdStb;
  assign nandDqOut = stb.rowSel ? rowByte : stb.lit;

  // R4
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    nandRdEn |=> (rdValid && rdData == $past(nandDqIn)));

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.waitOn |-> (waitCnt <= limitReg));

  // R3
  read_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    nandRdEn |-> (readIdx < lenReg));
endmodule

// File: rtl/nand_otp_fetch.sv
module nand_otp_fetch
  import otp_fetch_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [ROW_W-1:0] pageAddr,
  input  logic [LEN_W-1:0] byteLen,
  input  logic [TO_W-1:0]  busyLimit,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWrEn,
  output logic             nandRdEn,
  output logic [DQ_W-1:0]  nandDqOut,
  input  logic [DQ_W-1:0]  nandDqIn,
  input  logic             nandReady,
  output logic [DQ_W-1:0]  rdData,
  output logic             rdValid,
  output logic             busy,
  output logic             done,
  output logic             error
);
  strobeT stb;
  logic   waitDone;
  logic   waitFail;
  logic   readLast;
  logic   lenZero;

  otp_fetch_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .waitDone (waitDone),
    .waitFail (waitFail),
    .readLast (readLast),
    .lenZero  (lenZero),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  otp_fetch_dp #(.LEN_W(LEN_W), .TO_W(TO_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pageAddr  (pageAddr),
    .byteLen   (byteLen),
    .busyLimit (busyLimit),
    .nandDqIn  (nandDqIn),
    .nandReady (nandReady),
    .waitDone  (waitDone),
    .waitFail  (waitFail),
    .readLast  (readLast),
    .lenZero   (lenZero),
    .nandCle   (nandCle),
    .nandAle   (nandAle),
    .nandWrEn  (nandWrEn),
    .nandRdEn  (nandRdEn),
    .nandDqOut (nandDqOut),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );
endmodule

// File: tb/nand_otp_fetch_test.sv
module nand_otp_fetch_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] pageAddr = '0;
  logic [15:0] byteLen = '0;
  logic [15:0] busyLimit = '0;
  logic        nandCle, nandAle, nandWrEn, nandRdEn;
  logic [7:0]  nandDqOut;
  logic [7:0]  nandDqIn = '0;
  logic        nandReady = 1'b1;
  logic [7:0]  rdData;
  logic        rdValid, busy, done, error;

  always #5 clk = ~clk;

  nand_otp_fetch uut (
    .clk(clk), .rstN(rstN), .start(start), .pageAddr(pageAddr),
    .byteLen(byteLen), .busyLimit(busyLimit), .nandCle(nandCle),
    .nandAle(nandAle), .nandWrEn(nandWrEn), .nandRdEn(nandRdEn),
    .nandDqOut(nandDqOut), .nandDqIn(nandDqIn), .nandReady(nandReady),
    .rdData(rdData), .rdValid(rdValid), .busy(busy), .done(done),
    .error(error)
  );

  typedef struct packed {
    logic [23:0] page;
    logic [15:0] len;
    logic [15:0] limit;
    logic [7:0]  lat;
    logic [1:0]  failAt;
  } caseT;

  localparam int NCASE = 7;
  localparam caseT CASES [NCASE] = '{
    '{24'h00021F, 16'd784, 16'd20, 8'd4,  2'd0},
    '{24'h000200, 16'd528, 16'd20, 8'd4,  2'd0},
    '{24'h0ABCDE, 16'd5,   16'd6,  8'd7,  2'd0},
    '{24'h000003, 16'd3,   16'd6,  8'd8,  2'd0},
    '{24'h012345, 16'd4,   16'd10, 8'd3,  2'd2},
    '{24'h000077, 16'd6,   16'd10, 8'd3,  2'd3},
    '{24'h000005, 16'd0,   16'd10, 8'd2,  2'd0}
  };

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // device model and log
  int          logN, gotN, rdCnt, dataBad, doneCnt, evt, devIdx, busyCnt;
  int          curLat, curFail;
  logic        stuck = 1'b0;
  logic        errSeen;
  logic [23:0] curPage;
  logic [1:0]  logKind [64];
  logic [7:0]  logVal  [64];
  logic [1:0]  expKind [32];
  logic [7:0]  expVal  [32];
  int          expN;

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'(i >> 8) ^ 8'hA5 ^ curPage[7:0];
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      nandReady = 1'b1;
      busyCnt = 0;
    end else begin
      if (nandCle || nandAle || nandWrEn) begin
        if (logN < 64) begin
          logKind[logN] = nandCle ? 2'd0 : (nandAle ? 2'd1 : 2'd2);
          logVal[logN]  = nandDqOut;
        end
        logN++;
      end
      if (rdValid) begin
        if (rdData !== pat(gotN)) dataBad++;
        gotN++;
      end
      if (done) begin
        doneCnt++;
        errSeen = error;
      end
      if (nandRdEn) begin
        nandDqIn = pat(devIdx);
        devIdx++;
        rdCnt++;
      end
      if (nandCle && (nandDqOut == 8'hFF || nandDqOut == 8'h30)) begin
        evt++;
        devIdx = 0;
        nandReady = 1'b0;
        busyCnt = curLat;
        if (evt == curFail) stuck = 1'b1;
      end else if (!nandReady && !stuck) begin
        if (busyCnt <= 1) begin
          busyCnt = 0;
          nandReady = 1'b1;
        end else begin
          busyCnt--;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under 190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] v);
    expKind[expN] = k;
    expVal[expN]  = v;
    expN++;
  endtask

  // R2 R3 R5 R6: kind 0 command, 1 address, 2 data write
  task automatic buildExp(input logic [23:0] pg);
    expN = 0;
    push(0, 8'hFF); push(0, 8'h36); push(1, 8'h38); push(2, 8'h52);
    push(0, 8'h16); push(0, 8'h17); push(0, 8'h04); push(0, 8'h19);
    push(0, 8'h00); push(1, 8'h00); push(1, 8'h00);
    push(1, pg[7:0]); push(1, pg[15:8]); push(1, pg[23:16]);
    push(0, 8'h30);
    push(0, 8'hFF); push(0, 8'h36); push(1, 8'h38); push(2, 8'h00);
    push(0, 8'h16);
    push(0, 8'h00);
    for (int i = 0; i < 5; i++) push(1, 8'h00);
    push(0, 8'h30);
  endtask

  task automatic prepare(input caseT c);
    @(negedge clk);
    pageAddr = c.page;  byteLen = c.len;  busyLimit = c.limit;
    curPage = c.page;   curLat = c.lat;   curFail = c.failAt;
    logN = 0; gotN = 0; rdCnt = 0; dataBad = 0; doneCnt = 0; evt = 0;
    devIdx = 0; stuck = 1'b0; nandReady = 1'b1; errSeen = 1'b0;
    buildExp(c.page);
  endtask

  task automatic waitDoneEv();
    int n;
    n = 0;
    while (doneCnt == 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (doneCnt == 0) check(1'b0, "R6", "run never ended (cycles)", n, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input caseT c, input string tag);
    int expLen, expData, opBad, lim;
    bit expErr;
    if (c.failAt == 1 || int'(c.lat) >= int'(c.limit) + 2) begin
      expLen = 1;  expData = 0; expErr = 1'b1;
    end else if (c.failAt == 2) begin
      expLen = 15; expData = 0; expErr = 1'b1;
    end else if (c.failAt == 3) begin
      expLen = 16; expData = int'(c.len); expErr = 1'b1;
    end else begin
      expLen = 27; expData = int'(c.len); expErr = 1'b0;
    end
    opBad = 0;
    lim = (logN < expLen) ? logN : expLen;
    for (int i = 0; i < lim; i++)
      if (logKind[i] !== expKind[i] || logVal[i] !== expVal[i]) opBad++;
    check(logN == expLen, expErr ? "R7" : "R6", {tag, " bus op count"}, logN, expLen);
    check(opBad == 0, "R2 R3 R5", {tag, " bus op mismatches"}, opBad, 0);
    check(rdCnt == expData, c.len == 0 ? "R9" : "R3", {tag, " read strobes"}, rdCnt, expData);
    check(gotN == expData && dataBad == 0, "R4", {tag, " streamed bytes"}, gotN, expData);
    check(doneCnt == 1 && errSeen == expErr, expErr ? "R7" : "R6",
          {tag, " done/error"}, {doneCnt, errSeen}, {1, expErr});
    check(!busy && error == expErr, "R7", {tag, " idle flags"}, {busy, error}, {1'b0, expErr});
  endtask

  initial begin
    caseT d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error && !rdValid, "R1", "status after reset",
          {busy, done, error, rdValid}, 0);
    check(!(nandCle || nandAle || nandWrEn || nandRdEn), "R1", "strobes after reset",
          {nandCle, nandAle, nandWrEn, nandRdEn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !error, "R1", "idle after reset release",
          {busy, done, error}, 0);

    for (int k = 0; k < NCASE; k++) begin
      prepare(CASES[k]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitDoneEv();
      verify(CASES[k], $sformatf("case%0d", k));
    end

    // R8: start and config changes while busy are ignored
    d = '{24'h0000AA, 16'd8, 16'd20, 8'd4, 2'd0};
    prepare(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    pageAddr = 24'h00BB00;
    byteLen = 16'd2;
    busyLimit = 16'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDoneEv();
    check(busy == 1'b0, "R8", "busy after ignored start", busy, 0);
    verify(d, "r8_busy_start");

    // R7: error stays until next accepted start, which clears it
    d = '{24'h000011, 16'd1, 16'd3, 8'd2, 2'd1};
    prepare(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDoneEv();
    verify(d, "r7_stuck");
    d = '{24'h000012, 16'd2, 16'd20, 8'd2, 2'd0};
    prepare(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(!error && busy, "R7", "error cleared by new start", error, 0);
    waitDoneEv();
    verify(d, "r7_recover");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule